// File: doc/BRIEF.md
# Delta-Sigma Bitstream Modulator with Saturation Heartbeat

This block is a cycle-level digital model of a first-order delta-sigma modulator. On every clock it takes a signed 16-bit input level and produces one output bit. Over time, the proportion of ones in the output stream follows the input linearly: the density is 0.5 + x/65536. A nominal full-scale input of ±25600 gives densities of 89.0625 % and 10.9375 %. A downstream 16-bit averaging filter reads these as codes 58368 and 7168.

When the input sits at either extreme code (+32767 or −32768), the block treats it as clipped. The stream then locks to all ones (positive clip) or all zeros (negative clip). Even while locked, the block inserts a single opposite-polarity bit every 128 clocks, so a receiver can tell a saturated but working modulator from a dead line. A clip flag marks every output bit produced from a clipped sample.

Each output is registered. The bit and flag that follow a rising clock edge belong to the sample present at that edge.

Top module: `dsm_heartbeat_top`

## Requirements
- R1: A synchronous reset clears the accumulator, the marker phase and both outputs; bitOut and clipFlag read 0 after any edge with rst high.
- R2: With a constant input of 0, the number of ones over any 16384 consecutive outputs is 8192 ±1.
- R3: With a constant input of +25600, the ones count over 16384 outputs is 14592 ±1, which is 58368 on a 16-bit scale.
- R4: With a constant input of −25600, the ones count over 16384 outputs is 1792 ±1, which is 7168 on a 16-bit scale.
- R5: For any unclipped constant input x, the ones count over 16384 outputs is (x+32768)/4 ±1.
- R6: clipFlag is 1 after an edge exactly when the sample at that edge was +32767 or −32768; +32766 and −32767 leave it 0.
- R7: During a positive clip run, every output is 1 except the run's samples at index 127, 255, and so on (index counted from 0 at run entry), which are 0.
- R8: During a negative clip run, every output is 0 except the samples at index 127 mod 128, which are 1.
- R9: The marker phase restarts at index 0 whenever a clip run begins, either from an unclipped sample or by switching directly between the positive and negative limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | 16 | Signed input level |
| bitOut | output | 1 | Modulator output bit |
| clipFlag | output | 1 | High when the bit came from a clipped sample |

## Verification
The marker phase is the hardest state to observe. It only shows once a clip run has lasted 128 samples, and its restart rule matters only when a run is cut short or changes polarity. The stimulus therefore holds each limit for 300 samples, so two markers appear in each run. It then jumps straight from the positive limit to the negative limit with no unclipped sample in between. After a brief unclipped gap, it re-enters the positive limit and expects the first marker again at index 127, not at a phase carried over from the earlier run.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  parameter int DATA_W   = 16;
  parameter int PHASE_W  = 7;

  typedef struct packed {
    logic sat;       // current sample is at a limit
    logic satLevel;  // 1: positive limit, 0: negative limit
    logic marker;    // emit the opposite-polarity heartbeat bit
  } ctlStrobe_t;
endpackage

// File: rtl/dsm_control.sv
module dsm_control
  import dsm_pkg::*;
#(
  parameter int SAMPLE_W = DATA_W,
  parameter int PH_W     = PHASE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample,
  output ctlStrobe_t          strb
);
  localparam logic [SAMPLE_W-1:0] POS_LIM  = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_LIM  = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [PH_W-1:0]     LAST_PH  = {PH_W{1'b1}};

  logic            isPos, isNeg, satNow, entry;
  logic            prevSat, prevLevel;
  logic [PH_W-1:0] phaseCnt, phaseUse;

  always_comb begin
    isPos    = (sample == POS_LIM);
    isNeg    = (sample == NEG_LIM);
    satNow   = isPos | isNeg;
    entry    = satNow && (!prevSat || (prevLevel != isPos));
    phaseUse = entry ? '0 : phaseCnt;
    strb.sat      = satNow;
    strb.satLevel = isPos;
    strb.marker   = satNow && (phaseUse == LAST_PH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt  <= '0;
      prevSat   <= 1'b0;
      prevLevel <= 1'b0;
    end else begin
      phaseCnt  <= satNow ? phaseUse + 1'b1 : '0;
      prevSat   <= satNow;
      prevLevel <= isPos;
    end
  end

  // R7: heartbeat never fires on two consecutive samples
  a_r7_single_marker: assert property (@(posedge clk) disable iff (rst)
    strb.marker |=> !strb.marker);
  // R9: the first sample of any clip run is never a marker
  a_r9_entry_no_marker: assert property (@(posedge clk) disable iff (rst)
    entry |-> !strb.marker);
endmodule

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int SAMPLE_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample,
  input  ctlStrobe_t          strb,
  output logic                bitOut,
  output logic                clipFlag
);
  logic [SAMPLE_W-1:0] acc, offsetVal;
  logic [SAMPLE_W:0]   sum;

  always_comb begin
    offsetVal = sample ^ {1'b1, {(SAMPLE_W-1){1'b0}}};  // x + 2^(W-1)
    sum       = {1'b0, acc} + {1'b0, offsetVal};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      bitOut   <= 1'b0;
      clipFlag <= 1'b0;
    end else begin
      acc      <= sum[SAMPLE_W-1:0];
      bitOut   <= strb.sat ? (strb.satLevel ^ strb.marker) : sum[SAMPLE_W];
      clipFlag <= strb.sat;
    end
  end

  // R7: positive clip without marker yields a one
  a_r7_pos_ones: assert property (@(posedge clk) disable iff (rst)
    (strb.sat && strb.satLevel && !strb.marker) |=> bitOut);
  // R8: negative clip without marker yields a zero
  a_r8_neg_zeros: assert property (@(posedge clk) disable iff (rst)
    (strb.sat && !strb.satLevel && !strb.marker) |=> !bitOut);
endmodule

// File: rtl/dsm_heartbeat_top.sv
module dsm_heartbeat_top
  import dsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sample,
  output logic              bitOut,
  output logic              clipFlag
);
  ctlStrobe_t strb;

  dsm_control #(.SAMPLE_W(DATA_W), .PH_W(PHASE_W)) u_ctl (
    .clk(clk), .rst(rst), .sample(sample), .strb(strb));

  dsm_datapath #(.SAMPLE_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .sample(sample), .strb(strb),
    .bitOut(bitOut), .clipFlag(clipFlag));

  // R1: outputs are cleared after a reset edge
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!bitOut && !clipFlag));
  // R6: flag only follows a sample at a limit
  a_r6_flag_source: assert property (@(posedge clk) disable iff (rst)
    clipFlag |-> ($past(sample) == 16'h7FFF || $past(sample) == 16'h8000));
endmodule

// File: tb/dsm_heartbeat_top_bench.sv
module dsm_heartbeat_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sample = '0;
  logic        bitOut, clipFlag;

  int checks = 0;
  int fails  = 0;
  int onesCnt = 0;
  bit done = 0;

  typedef struct {
    bit    chkBit;
    bit    expBit;
    bit    expClip;
    string req;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  dsm_heartbeat_top u_dsm_heartbeat_top (
    .clk(clk), .rst(rst), .sample(sample), .bitOut(bitOut), .clipFlag(clipFlag));

  // monitor: pops one expectation per edge
  initial forever begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (clipFlag !== it.expClip) begin
        fails++;
        $display("FAIL %s clipFlag actual=%0b expected=%0b", it.req, clipFlag, it.expClip);
      end
      if (it.chkBit) begin
        checks++;
        if (bitOut !== it.expBit) begin
          fails++;
          $display("FAIL %s bitOut actual=%0b expected=%0b", it.req, bitOut, it.expBit);
        end
      end else if (bitOut === 1'b1) onesCnt++;
    end
  end

  task automatic drive(input logic [15:0] x, input bit cb, input bit eb,
                       input bit ec, input string req);
    item_t it;
    @(negedge clk);
    sample = x;
    it.chkBit = cb; it.expBit = eb; it.expClip = ec; it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic density(input int x, input string req);
    int expc, diff;
    expc = (x + 32768) / 4;
    drive(x[15:0], 0, 0, 0, req);   // settle one sample
    drain();
    onesCnt = 0;
    for (int i = 0; i < 16384; i++) drive(x[15:0], 0, 0, 0, req);
    drain();
    diff = onesCnt - expc;
    checks++;
    if (diff > 1 || diff < -1) begin
      fails++;
      $display("FAIL %s ones actual=%0d expected=%0d", req, onesCnt, expc);
    end
  endtask

  // clip run: level 1 positive, 0 negative; marker at index%128==127
  task automatic clipRun(input bit pos, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      bit mk;
      mk = (i % 128) == 127;
      drive(pos ? 16'h7FFF : 16'h8000, 1, pos ^ mk, 1, req);
    end
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (bitOut !== 1'b0 || clipFlag !== 1'b0) begin
      fails++;
      $display("FAIL R1 bit/flag actual=%0b%0b expected=00", bitOut, clipFlag);
    end
    rst = 1'b0;

    density(0, "R2");
    density(25600, "R3");
    density(-25600, "R4");
    density(1000, "R5");

    // R6: near-limit values do not flag
    drive(16'h7FFE, 0, 0, 0, "R6");
    drive(16'h8001, 0, 0, 0, "R6");
    // R7 then direct switch to R8 (R9 polarity restart)
    clipRun(1, 300, "R7");
    clipRun(0, 300, "R8_R9");
    for (int i = 0; i < 3; i++) drive(16'h0000, 0, 0, 0, "R6");
    // R9: re-entry restarts phase
    clipRun(1, 100, "R9");
    drive(16'h0000, 0, 0, 0, "R9");
    clipRun(1, 130, "R9");
    drain();

    // R1: reset mid clip clears outputs
    @(negedge clk);
    sample = 16'h7FFF;
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (bitOut !== 1'b0 || clipFlag !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset actual=%0b%0b expected=00", bitOut, clipFlag);
    end
    @(negedge clk);
    rst = 1'b0;
    clipRun(0, 130, "R1_R9");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule